// File: doc/BRIEF.md
# In-Lane Vector Shuffle and Permute Unit

This unit rearranges the elements of 256-bit vectors. It treats each vector as two 128-bit lanes. Inside a lane it selects 32-bit (single) or 64-bit (double) elements. The selection comes either from an 8-bit immediate or from a per-element control vector, and an element never moves out of its lane. A separate half-select mode builds each 128-bit half of the result from any half of either source, and can also force that half to zero.

The caller drives an operation code, a length flag, two sources, a control vector and the immediate, and pulses `start` for one cycle. One clock edge later the registered result appears and `resValid` is high for exactly one cycle. The result register keeps its value until the next start.

Top module: `lane_perm_unit`

## Requirements
- R1: While `rstN` is low, and after it is released, `resValid` is 0 and `result` is all zeros until the first start.
- R2: `resValid` is high in the cycle after each cycle in which `start` is high, and low otherwise. `result` changes only on the edge that samples `start` high.
- R3: Op 0 (two-source single shuffle): in each lane, result elements 0 and 1 take the `srcA` elements indexed by `imm[1:0]` and `imm[3:2]`. Result elements 2 and 3 take the `srcB` elements indexed by `imm[5:4]` and `imm[7:6]`. Both lanes use the same fields.
- R4: Op 1 (two-source double shuffle): in lane L, result element 0 is `srcA` element `imm[2L]` and result element 1 is `srcB` element `imm[2L+1]`, both indexed within that lane.
- R5: Op 2 (single permute by immediate): result element e of each lane is the `srcA` element of the same lane indexed by `imm[2e+1:2e]`. `srcB` has no effect.
- R6: Op 3 (double permute by immediate): result element e of lane L is the `srcA` element of lane L indexed by `imm[2L+e]`.
- R7: Op 4 (variable single permute): result element k is the `srcA` element of the same lane indexed by bits [1:0] of 32-bit control element k. The other control bits have no effect.
- R8: Op 5 (variable double permute): result element k is the `srcA` element of the same lane indexed by bit 1 of 64-bit control element k. The other control bits have no effect.
- R9: Op 6 (half select): the low result half is set by `imm[3:0]` and the high half by `imm[7:4]`. In each nibble, bit 1 chooses `srcB` over `srcA` and bit 0 chooses the upper 128 bits of that source.
- R10: In op 6, a nibble with bit 3 set zeroes its result half whatever the other bits are. Bit 2 of a nibble has no effect.
- R11: With `wideLen` = 0, ops 0 to 5 yield zeros in `result[255:128]`. Op 6 always yields a full 256-bit result.
- R12: Op 7 yields an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to compute and register a result |
| opSel | input | 3 | Operation code (0 to 7) |
| wideLen | input | 1 | 1 = 256-bit length, 0 = 128-bit length |
| srcA | input | 256 | First source vector |
| srcB | input | 256 | Second source vector |
| ctrlVec | input | 256 | Per-element control for the variable permutes |
| imm | input | 8 | Immediate selector |
| resValid | output | 1 | High for one cycle when a new result is available |
| result | output | 256 | Registered result vector |

## Verification
The assertions take for granted that `opSel`, `wideLen`, `imm`, `srcA` and `srcB` hold known values in every cycle in which `start` is high. They also take for granted that `start` itself is never unknown after reset. The bench drives every input from a defined value at all times and changes inputs only on the falling edge, so each sampled request is stable and fully defined. The idle cycles between requests put fresh random values on the data inputs, which checks that a start-free cycle leaves the result untouched.

// File: rtl/lane_perm_pkg.sv
`timescale 1ns/1ps
package lane_perm_pkg;
  parameter int VEC_W  = 256;
  parameter int LANE_W = 128;
  parameter int SGL_W  = 32;
  parameter int DBL_W  = 64;
  parameter int IMM_W  = 8;
  parameter int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SHUF_SGL  = 3'd0,
    OP_SHUF_DBL  = 3'd1,
    OP_PERMI_SGL = 3'd2,
    OP_PERMI_DBL = 3'd3,
    OP_PERMV_SGL = 3'd4,
    OP_PERMV_DBL = 3'd5,
    OP_HALF_SEL  = 3'd6,
    OP_RSVD      = 3'd7
  } perm_op_e;

  // Strobes from the control decoder into the datapath
  typedef struct packed {
    logic load;       // register a new result this edge
    logic isDouble;   // 64-bit element granularity
    logic useVar;     // indices from ctrlVec instead of imm
    logic twoSrc;     // upper element slots come from srcB
    logic halfSel;    // 128-bit half select path
    logic zeroAll;    // force whole result to zero
    logic clearHigh;  // zero result bits above one lane
  } perm_ctrl_t;
endpackage

// File: rtl/lane_perm_ctrl.sv
`timescale 1ns/1ps
module lane_perm_ctrl
  import lane_perm_pkg::*;
#(
  parameter int OPW = OP_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [OPW-1:0] opSel,
  input  logic           wideLen,
  output perm_ctrl_t     strobes,
  output logic           resValid
);

  always_comb begin
    strobes      = '0;
    strobes.load = start;
    unique case (perm_op_e'(opSel))
      OP_SHUF_SGL:  strobes.twoSrc = 1'b1;
      OP_SHUF_DBL: begin
        strobes.twoSrc   = 1'b1;
        strobes.isDouble = 1'b1;
      end
      OP_PERMI_SGL: ;
      OP_PERMI_DBL: strobes.isDouble = 1'b1;
      OP_PERMV_SGL: strobes.useVar = 1'b1;
      OP_PERMV_DBL: begin
        strobes.useVar   = 1'b1;
        strobes.isDouble = 1'b1;
      end
      OP_HALF_SEL:  strobes.halfSel = 1'b1;
      default:      strobes.zeroAll = 1'b1;
    endcase
    strobes.clearHigh = !wideLen && !strobes.halfSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= start;
  end

endmodule

// File: rtl/lane_perm_dp.sv
`timescale 1ns/1ps
module lane_perm_dp
  import lane_perm_pkg::*;
#(
  parameter int VW   = VEC_W,
  parameter int LW   = LANE_W,
  parameter int SW   = SGL_W,
  parameter int DW   = DBL_W,
  parameter int IW   = IMM_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  perm_ctrl_t    strobes,
  input  logic [VW-1:0] srcA,
  input  logic [VW-1:0] srcB,
  input  logic [VW-1:0] ctrlVec,
  input  logic [IW-1:0] imm,
  output logic [VW-1:0] result
);

  localparam int NLANES = VW / LW;
  localparam int S_PER  = LW / SW;
  localparam int D_PER  = LW / DW;
  localparam int SIDX_W = $clog2(S_PER);
  localparam int DIDX_W = (D_PER > 1) ? $clog2(D_PER) : 1;
  localparam int NIB_W  = IW / NLANES;

  logic [VW-1:0] singleVec;
  logic [VW-1:0] doubleVec;
  logic [VW-1:0] halfVec;
  logic [VW-1:0] nextRes;

  // Sink for control bits that no mode consumes
  logic unusedCtrlBits;
  assign unusedCtrlBits = ^ctrlVec;

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    // 32-bit element selection
    for (genvar e = 0; e < S_PER; e++) begin : g_sgl
      localparam bit UPPER = (e >= S_PER / 2);
      logic [SIDX_W-1:0]         sIdx;
      logic [S_PER-1:0][SW-1:0]  sLane;
      always_comb begin
        sIdx  = strobes.useVar ? ctrlVec[(l*S_PER+e)*SW +: SIDX_W]
                               : imm[e*SIDX_W +: SIDX_W];
        sLane = (strobes.twoSrc && UPPER) ? srcB[l*LW +: LW]
                                          : srcA[l*LW +: LW];
      end
      assign singleVec[(l*S_PER+e)*SW +: SW] = sLane[sIdx];
    end

    // 64-bit element selection
    for (genvar e = 0; e < D_PER; e++) begin : g_dbl
      localparam bit UPPER = (e >= D_PER / 2);
      logic [DIDX_W-1:0]         dIdx;
      logic [D_PER-1:0][DW-1:0]  dLane;
      always_comb begin
        dIdx  = strobes.useVar ? DIDX_W'(ctrlVec[(l*D_PER+e)*DW + 1])
                               : DIDX_W'(imm[l*D_PER+e]);
        dLane = (strobes.twoSrc && UPPER) ? srcB[l*LW +: LW]
                                          : srcA[l*LW +: LW];
      end
      assign doubleVec[(l*D_PER+e)*DW +: DW] = dLane[dIdx];
    end

    // Whole-lane select with forced zero
    logic [NIB_W-1:0]           nib;
    logic [NLANES-1:0][LW-1:0]  hSrc;
    always_comb begin
      nib  = imm[l*NIB_W +: NIB_W];
      hSrc = nib[1] ? srcB : srcA;
    end
    assign halfVec[l*LW +: LW] = nib[3] ? '0 : hSrc[nib[0]];
  end

  always_comb begin
    if (strobes.zeroAll)       nextRes = '0;
    else if (strobes.halfSel)  nextRes = halfVec;
    else if (strobes.isDouble) nextRes = doubleVec;
    else                       nextRes = singleVec;
    if (strobes.clearHigh)     nextRes[VW-1:LW] = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             result <= '0;
    else if (strobes.load) result <= nextRes;
  end

endmodule

// File: rtl/lane_perm_unit.sv
`timescale 1ns/1ps
module lane_perm_unit
  import lane_perm_pkg::*;
#(
  parameter int VW = VEC_W,
  parameter int LW = LANE_W,
  parameter int IW = IMM_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [2:0]    opSel,
  input  logic          wideLen,
  input  logic [VW-1:0] srcA,
  input  logic [VW-1:0] srcB,
  input  logic [VW-1:0] ctrlVec,
  input  logic [IW-1:0] imm,
  output logic          resValid,
  output logic [VW-1:0] result
);

  perm_ctrl_t strobes;

  lane_perm_ctrl #(.OPW(3)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .wideLen(wideLen), .strobes(strobes), .resValid(resValid)
  );

  lane_perm_dp #(.VW(VW), .LW(LW), .SW(SGL_W), .DW(DBL_W), .IW(IW)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .srcA(srcA), .srcB(srcB),
    .ctrlVec(ctrlVec), .imm(imm), .result(result)
  );

endmodule

// File: rtl/lane_perm_checker.sv
`timescale 1ns/1ps
module lane_perm_checker (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic [2:0]   opSel,
  input logic         wideLen,
  input logic [255:0] srcA,
  input logic [255:0] srcB,
  input logic [7:0]   imm,
  input logic         resValid,
  input logic [255:0] result
);

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    start |=> resValid); // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !resValid); // R2

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> $stable(result)); // R2

  AST_NARROW_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (start && !wideLen && opSel != 3'd6) |=> (result[255:128] == '0)); // R11

  AST_HALF_LOW_FORCED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (start && opSel == 3'd6 && imm[3]) |=> (result[127:0] == '0)); // R10

  AST_HALF_HIGH_FROM_B_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (start && opSel == 3'd6 && imm[7:4] == 4'b0011)
      |=> (result[255:128] == $past(srcB[255:128]))); // R9

  AST_HALF_LOW_FROM_A_LOWER: assert property (@(posedge clk) disable iff (!rstN)
    (start && opSel == 3'd6 && imm[3:0] == 4'b0000)
      |=> (result[127:0] == $past(srcA[127:0]))); // R9

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (start && opSel == 3'd7) |=> (result == '0)); // R12

endmodule

bind lane_perm_unit lane_perm_checker u_chk (
  .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .wideLen(wideLen),
  .srcA(srcA), .srcB(srcB), .imm(imm), .resValid(resValid), .result(result)
);

// File: tb/lane_perm_unit_bench.sv
`timescale 1ns/1ps
module lane_perm_unit_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [2:0]   opSel = '0;
  logic         wideLen = 1'b1;
  logic [255:0] srcA = '0, srcB = '0, ctrlVec = '0;
  logic [7:0]   imm = '0;
  logic         resValid;
  logic [255:0] result;

  int checks = 0;
  int failures = 0;
  bit running = 0;
  bit done = 0;

  string curTag = "R2";
  string expTag = "R2";
  logic         expValid = 1'b0;
  logic [255:0] expRes = '0;

  always #4 clk = ~clk;

  lane_perm_unit u_lane_perm_unit (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .wideLen(wideLen),
    .srcA(srcA), .srcB(srcB), .ctrlVec(ctrlVec), .imm(imm),
    .resValid(resValid), .result(result)
  );

  // Behavioural reference of one request
  function automatic logic [255:0] model(input int op, input bit wide,
      input logic [255:0] a, input logic [255:0] b, input logic [255:0] c,
      input logic [7:0] im);
    logic [255:0] r = '0;
    logic [255:0] src;
    int idx;
    for (int l = 0; l < 2; l++) begin
      if (op == 0 || op == 2 || op == 4) begin
        for (int e = 0; e < 4; e++) begin
          if (op == 4) idx = int'(c[(l*4+e)*32 +: 2]);
          else         idx = int'(im[e*2 +: 2]);
          src = (op == 0 && e >= 2) ? b : a;
          r[(l*4+e)*32 +: 32] = src[(l*4+idx)*32 +: 32];
        end
      end else if (op == 1 || op == 3 || op == 5) begin
        for (int e = 0; e < 2; e++) begin
          if (op == 5) idx = int'(c[(l*2+e)*64 + 1]);
          else         idx = int'(im[l*2+e]);
          src = (op == 1 && e == 1) ? b : a;
          r[(l*2+e)*64 +: 64] = src[(l*2+idx)*64 +: 64];
        end
      end else if (op == 6) begin
        if (im[l*4+3]) r[l*128 +: 128] = '0;
        else begin
          src = im[l*4+1] ? b : a;
          r[l*128 +: 128] = src[int'(im[l*4]) * 128 +: 128];
        end
      end
    end
    if (op != 6 && !wide) r[255:128] = '0;
    return r;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expValid <= 1'b0;
      expRes   <= '0;
    end else begin
      expValid <= start;
      if (start) begin
        expRes <= model(int'(opSel), wideLen, srcA, srcB, ctrlVec, imm);
        expTag <= curTag;
      end
    end
  end

  // Compare every clock, away from the active edge
  always @(negedge clk) begin
    if (running && rstN) begin
      checks++;
      if (resValid !== expValid) begin
        failures++;
        $display("FAIL R2 resValid actual=%b expected=%b", resValid, expValid);
      end
      checks++;
      if (result !== expRes) begin
        failures++;
        $display("FAIL %s result actual=%h expected=%h", expTag, result, expRes);
      end
    end
  end

  function automatic logic [255:0] rnd256();
    return {$urandom(), $urandom(), $urandom(), $urandom(),
            $urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic issue(input int op, input bit wide, input logic [255:0] a,
      input logic [255:0] b, input logic [255:0] c, input logic [7:0] im,
      input string tag);
    @(negedge clk);
    opSel = op[2:0]; wideLen = wide; srcA = a; srcB = b; ctrlVec = c; imm = im;
    curTag = tag; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // idle cycle with disturbed inputs: result must hold (R2)
    srcA = rnd256(); srcB = rnd256(); ctrlVec = rnd256(); imm = 8'($urandom());
    opSel = 3'($urandom());
  endtask

  logic [255:0] pa, pb;

  initial begin
    for (int i = 0; i < 8; i++) begin
      pa[i*32 +: 32] = 32'hA000_0000 + i;
      pb[i*32 +: 32] = 32'hB000_0000 + i;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (resValid !== 1'b0 || result !== '0) begin
      failures++;
      $display("FAIL R1 during reset actual=%b/%h expected=0/0", resValid, result);
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (resValid !== 1'b0 || result !== '0) begin
      failures++;
      $display("FAIL R1 after reset actual=%b/%h expected=0/0", resValid, result);
    end
    running = 1;

    issue(0, 1, pa, pb, '0, 8'b11_10_01_00, "R3");
    issue(0, 1, pa, pb, '0, 8'b00_01_10_11, "R3");
    issue(1, 1, pa, pb, '0, 8'b0000_1001, "R4");
    issue(1, 1, pa, pb, '0, 8'b0000_0110, "R4");
    issue(2, 1, pa, rnd256(), '0, 8'b00_00_11_10, "R5");
    issue(2, 1, pa, '1, '0, 8'b01_11_00_10, "R5");
    issue(3, 1, pa, pb, '0, 8'b0000_1010, "R6");
    issue(3, 1, pa, pb, '0, 8'b0000_0101, "R6");
    issue(4, 1, pa, pb, {8{32'hFFFF_FFF3}}, 8'h00, "R7");
    issue(4, 1, pa, pb, rnd256(), 8'hFF, "R7");
    issue(5, 1, pa, pb, {4{64'hFFFF_FFFF_FFFF_FFFD}}, 8'h00, "R8");
    issue(5, 1, pa, pb, {64'h2, 64'h0, 64'h0, 64'h2}, 8'hFF, "R8");
    issue(6, 1, pa, pb, '0, 8'b0011_0000, "R9");
    issue(6, 1, pa, pb, '0, 8'b0001_0010, "R9");
    issue(6, 0, pa, pb, '0, 8'b0010_0011, "R9");
    issue(6, 1, pa, pb, '0, 8'b1011_0111, "R10");
    issue(6, 1, pa, pb, '0, 8'b0110_1001, "R10");
    issue(0, 0, pa, pb, '0, 8'hE4, "R11");
    issue(5, 0, pa, pb, rnd256(), 8'h00, "R11");
    issue(6, 0, pa, pb, '0, 8'b0011_0001, "R11");
    issue(7, 1, pa, pb, rnd256(), 8'hFF, "R12");

    // back-to-back starts
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      opSel = 3'($urandom()); wideLen = 1'($urandom());
      srcA = rnd256(); srcB = rnd256(); ctrlVec = rnd256(); imm = 8'($urandom());
      curTag = "R2"; start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;

    for (int k = 0; k < 400; k++)
      issue(int'($urandom() % 8), 1'($urandom()), rnd256(), rnd256(), rnd256(),
            8'($urandom()), "R3");
    repeat (3) @(negedge clk);
    running = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule